// File: doc/BRIEF.md
# Glitch-free generic clock generator

The block drives one generated clock from one of several free-running source clocks. Software programs a single control word through a register-clock write port. The word holds an enable bit, a source select, a divide-enable bit and a division factor. With the divider bypassed, the output repeats the selected source. With the divider active, the output is a 50% duty clock whose period is 2×(factor+1) source periods.

Starting and stopping are handled by a four-phase handshake between the register domain and the selected source domain. A run request crosses into the source domain through a two-stage synchroniser. There a gate flop clocked on the source falling edge opens or closes the output, and it only moves while the clock it gates is low. The gate state comes back through a second synchroniser. The enable bit keeps reading one until that echo shows the gate shut.

A sleep input pauses a running output the same way a disable does. The output resumes by itself when sleep ends. The register FSM has six states:

- GC_OFF: idle.
- GC_START: request raised, waiting for the gate echo.
- GC_ON: running.
- GC_STOP: disable pending.
- GC_NAP: sleep pending.
- GC_DOZE: asleep with the enable bit still set.

The transitions are:

- OFF→START on an enable write without sleep.
- OFF→DOZE on an enable write during sleep.
- START→ON when the echo is high.
- ON→STOP on a write with enable zero.
- ON→NAP on sleep.
- STOP→OFF and NAP→DOZE when the echo is low.
- DOZE→START on wake.
- DOZE→OFF on a write with enable zero.

Top module: `gclk_gen`

## Requirements
- R1: After reset `gclk_out` is low and `reg_rdata` is all zero.
- R2: Control word layout with the defaults (SEL_W=2, DIV_W=8):
  - bit 0 is the enable bit.
  - bit 1 is divide-enable.
  - bits [3:2] are the source select.
  - bits [11:4] are the division factor.
  - A write made in the off state stores all fields, and bits [11:1] read back as written.
- R3: With divide-enable zero, the output has the period and high time of the source chosen by the select field.
- R4: With divide-enable one, the output period is 2×(factor+1) source periods, with a high time of (factor+1) source periods.
- R5: After an enable write the output starts with no further action, and its first high phase has full length.
- R6: After a write with enable zero, bit 0 still reads one on the next register cycle. It returns to zero only once the gate has closed, and after that no further output edge appears. No output high pulse is ever shorter than a full one.
- R7: While a disable or sleep entry is pending (the GC_STOP or GC_NAP state), every write is ignored, enable bit included.
- R8: While the generator is enabled (start, running or asleep), a write may only clear the enable bit. Writes to divide-enable, select and factor are ignored, and the output keeps its frequency.
- R9: While `sleep_req` is high a running output stops with whole pulses and bit 0 reads one. When `sleep_req` falls the output resumes at the programmed frequency without a write.
- R10: An enable write made while `sleep_req` is high produces no output until sleep ends. The output then starts on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_src | input | N_SRC | Free-running source clocks |
| sleep_req | input | 1 | Sleep request, register domain, high pauses the output |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | REG_W | Control word to write |
| reg_rdata | output | REG_W | Control word read-back with live enable status |
| gclk_out | output | 1 | Generated clock |

## Verification
The FSM state is mirrored in bit 0 of the read-back. A stuck or skipped state therefore shows up in the register cycle after the write as a wrong bit 0 or as fields that moved. A faulty divider or preload shows up in the first output pulse after enable, as a wrong first high time or period within one output period. A gate that closes at the wrong moment shows up as a truncated high pulse or a stray edge within a few source cycles of the disable or the sleep.

// File: rtl/gclk_pkg.sv
`timescale 1ns/1ps
package gclk_pkg;

    // register-domain handshake states
    typedef enum logic [2:0] {
        GC_OFF   = 3'd0,
        GC_START = 3'd1,
        GC_ON    = 3'd2,
        GC_STOP  = 3'd3,
        GC_NAP   = 3'd4,
        GC_DOZE  = 3'd5
    } gc_state_e;

    localparam int CEN_BIT   = 0;
    localparam int DIVEN_BIT = 1;
    localparam int SEL_LSB   = 2;

endpackage

// File: rtl/gclk_sync.sv
`timescale 1ns/1ps
module gclk_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gclk_regfsm.sv
`timescale 1ns/1ps
module gclk_regfsm
    import gclk_pkg::*;
#(
    parameter int SEL_W = 2,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             wr_cen,
    input  logic             wr_div_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DIV_W-1:0] wr_div,
    input  logic             sleep,
    input  logic             ack,
    output logic             req,
    output logic             rd_cen,
    output logic             cfg_div_en,
    output logic [SEL_W-1:0] cfg_sel,
    output logic [DIV_W-1:0] cfg_div,
    output gc_state_e        state
);
    gc_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GC_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GC_OFF: begin
                if (wr && wr_cen) begin
                    state_d = sleep ? GC_DOZE : GC_START;
                end
            end
            GC_START: begin
                if (ack) begin
                    state_d = GC_ON;
                end
            end
            GC_ON: begin
                if (wr && !wr_cen) begin
                    state_d = GC_STOP;
                end else if (sleep) begin
                    state_d = GC_NAP;
                end
            end
            GC_STOP: begin
                if (!ack) begin
                    state_d = GC_OFF;
                end
            end
            GC_NAP: begin
                if (!ack) begin
                    state_d = GC_DOZE;
                end
            end
            GC_DOZE: begin
                if (wr && !wr_cen) begin
                    state_d = GC_OFF;
                end else if (!sleep) begin
                    state_d = GC_START;
                end
            end
            default: state_d = GC_OFF;
        endcase
    end

    // outputs
    always_comb begin
        req    = (state_q == GC_START) || (state_q == GC_ON);
        rd_cen = (state_q != GC_OFF);
    end

    // configuration fields load only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_div_en <= 1'b0;
            cfg_sel    <= '0;
            cfg_div    <= '0;
        end else if (wr && (state_q == GC_OFF)) begin
            cfg_div_en <= wr_div_en;
            cfg_sel    <= wr_sel;
            cfg_div    <= wr_div;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/gclk_core.sv
`timescale 1ns/1ps
module gclk_core #(
    parameter int N_SRC = 4,
    parameter int SEL_W = 2,
    parameter int DIV_W = 8
) (
    input  logic [N_SRC-1:0] clk_src,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             div_en,
    input  logic [DIV_W-1:0] div,
    input  logic             req,
    output logic             gate_on,
    output logic             gclk
);
    logic             src_clk;
    logic             req_s;
    logic [DIV_W-1:0] cnt_q;
    logic             dclk_q;
    logic             gate_q;

    // source select; only changes while the gate is shut
    always_comb begin
        src_clk = clk_src[0];
        for (int i = 1; i < N_SRC; i++) begin
            if (sel == SEL_W'(i)) begin
                src_clk = clk_src[i];
            end
        end
    end

    gclk_sync #(.W(1), .STAGES(2)) req_sync_i (
        .clk   (src_clk),
        .rst_n (rst_n),
        .d     (req),
        .q     (req_s)
    );

    // divider: preloaded while gated so the first edge after opening is a rise
    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            dclk_q <= 1'b0;
        end else if (!gate_q) begin
            cnt_q  <= div;
            dclk_q <= 1'b0;
        end else if (cnt_q == div) begin
            cnt_q  <= '0;
            dclk_q <= ~dclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // gate moves on the source falling edge while the gated clock is low
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if (!div_en || !dclk_q) begin
            gate_q <= req_s;
        end
    end

    assign gate_on = gate_q;
    assign gclk    = gate_q & (div_en ? dclk_q : src_clk);
endmodule

// File: rtl/gclk_gen.sv
`timescale 1ns/1ps
module gclk_gen
    import gclk_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int DIV_W = 8,
    parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    parameter int REG_W = 2 + SEL_W + DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] clk_src,
    input  logic             sleep_req,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             gclk_out
);
    localparam int DIV_LSB = SEL_LSB + SEL_W;

    logic             req;
    logic             rd_cen;
    logic             cfg_div_en;
    logic [SEL_W-1:0] cfg_sel;
    logic [DIV_W-1:0] cfg_div;
    logic             gate_on;
    logic             ack_s;
    gc_state_e        state_q;

    gclk_regfsm #(.SEL_W(SEL_W), .DIV_W(DIV_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .wr_cen     (reg_wdata[CEN_BIT]),
        .wr_div_en  (reg_wdata[DIVEN_BIT]),
        .wr_sel     (reg_wdata[SEL_LSB +: SEL_W]),
        .wr_div     (reg_wdata[DIV_LSB +: DIV_W]),
        .sleep      (sleep_req),
        .ack        (ack_s),
        .req        (req),
        .rd_cen     (rd_cen),
        .cfg_div_en (cfg_div_en),
        .cfg_sel    (cfg_sel),
        .cfg_div    (cfg_div),
        .state      (state_q)
    );

    gclk_core #(.N_SRC(N_SRC), .SEL_W(SEL_W), .DIV_W(DIV_W)) core_i (
        .clk_src (clk_src),
        .rst_n   (rst_n),
        .sel     (cfg_sel),
        .div_en  (cfg_div_en),
        .div     (cfg_div),
        .req     (req),
        .gate_on (gate_on),
        .gclk    (gclk_out)
    );

    gclk_sync #(.W(1), .STAGES(2)) ack_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gate_on),
        .q     (ack_s)
    );

    assign reg_rdata = {cfg_div, cfg_sel, cfg_div_en, rd_cen};
endmodule

// File: rtl/gclk_gen_chk.sv
`timescale 1ns/1ps
module gclk_gen_chk
    import gclk_pkg::*;
#(
    parameter int REG_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input gc_state_e        state,
    input logic             ack,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_rdata
);
    // R6: enable reads zero only with the gate echo low
    assert_off_gate_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[CEN_BIT] |-> !ack);

    // R7: pending disable or sleep entry freezes the whole word
    assert_pending_write_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (state == GC_STOP || state == GC_NAP)) |=> $stable(reg_rdata));

    // R8: enabled generator keeps its fields
    assert_run_fields_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && state != GC_OFF) |=> $stable(reg_rdata[REG_W-1:1]));

    // R5: running state only with the gate open
    assert_on_gate_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GC_ON) |-> ack);

    // R9: asleep means the gate is shut
    assert_doze_gate_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GC_DOZE) |-> !ack);
endmodule

bind gclk_gen gclk_gen_chk #(.REG_W(REG_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .ack       (ack_s),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata)
);

// File: tb/gclk_gen_tb.sv
`timescale 1ns/1ps
module gclk_gen_tb_top;
    localparam int N_SRC = 4;
    localparam int SEL_W = 2;
    localparam int DIV_W = 8;
    localparam int REG_W = 2 + SEL_W + DIV_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SRC-1:0] clk_src = '0;
    logic             sleep_req = 1'b0;
    logic             reg_wr = 1'b0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic             gclk_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // measurement of the generated clock
    real last_rise = -1.0;
    real period = 0.0;
    real high_t = 0.0;
    real first_high = 0.0;
    real min_high = 1.0e9;
    int  rises = 0;

    gclk_gen #(.N_SRC(N_SRC), .DIV_W(DIV_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_src   (clk_src),
        .sleep_req (sleep_req),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .gclk_out  (gclk_out)
    );

    always #2.5 clk = ~clk;
    always #5.0 clk_src[0] = ~clk_src[0];
    always #7.0 clk_src[1] = ~clk_src[1];
    always #3.0 clk_src[2] = ~clk_src[2];
    always #11.0 clk_src[3] = ~clk_src[3];

    always @(posedge gclk_out) begin
        if (last_rise >= 0.0) period = $realtime - last_rise;
        last_rise = $realtime;
        rises++;
    end

    always @(negedge gclk_out) begin
        high_t = $realtime - last_rise;
        if (rises == 1) first_high = high_t;
        if (high_t < min_high) min_high = high_t;
    end

    function automatic logic [REG_W-1:0] word(input bit cen, input bit den,
                                              input int sel, input int dv);
        return {DIV_W'(dv), SEL_W'(sel), den, cen};
    endfunction

    task automatic chk_int(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_real(input string tag, input real act, input real exp);
        n_chk++;
        if ((act - exp) > 0.01 || (exp - act) > 0.01) begin
            n_bad++;
            $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic [REG_W-1:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic clear_meas();
        last_rise = -1.0;
        period = 0.0;
        first_high = 0.0;
        min_high = 1.0e9;
        rises = 0;
    endtask

    task automatic wait_off(input string tag);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!reg_rdata[0]) break;
        end
        chk_int({tag, " enable bit clears"}, reg_rdata[0], 0);
    endtask

    // R1
    task automatic t_reset();
        chk_int("R1 rdata after reset", reg_rdata, 0);
        chk_int("R1 gclk_out after reset", gclk_out, 0);
    endtask

    // R2 R3 R5 R6 R7 on source 0, no divider
    task automatic t_plain();
        int r0;
        clear_meas();
        write_word(word(1, 0, 0, 0));
        chk_int("R2 readback", reg_rdata, word(1, 0, 0, 0));
        #300;
        chk_real("R3 period src0", period, 10.0);
        chk_real("R3 high src0", high_t, 5.0);
        chk_real("R5 first high src0", first_high, 5.0);
        write_word(word(0, 0, 0, 0));
        chk_int("R6 enable still reads one", reg_rdata[0], 1);
        write_word(word(1, 1, 3, 5));
        chk_int("R7 write during stop ignored", reg_rdata, word(1, 0, 0, 0));
        wait_off("R6");
        r0 = rises;
        #200;
        chk_int("R6 no edge after off", rises, r0);
        chk_real("R6 no short pulse", min_high, 5.0);
        chk_int("R7 fields kept", reg_rdata, word(0, 0, 0, 0));
    endtask

    // R4 R5 with factor 0 on source 1
    task automatic t_div0();
        clear_meas();
        write_word(word(1, 1, 1, 0));
        #300;
        chk_real("R4 period div0", period, 28.0);
        chk_real("R4 high div0", high_t, 14.0);
        chk_real("R5 first high div0", first_high, 14.0);
        write_word(word(0, 0, 0, 0));
        wait_off("R6 div0");
    endtask

    // R4 R5 R8 R9 with factor 2 on source 2
    task automatic t_div2_sleep();
        int r0;
        clear_meas();
        write_word(word(1, 1, 2, 2));
        #400;
        chk_real("R4 period div2", period, 36.0);
        chk_real("R4 high div2", high_t, 18.0);
        chk_real("R5 first high div2", first_high, 18.0);
        write_word(word(1, 0, 3, 7));
        chk_int("R8 fields ignored while on", reg_rdata, word(1, 1, 2, 2));
        #200;
        chk_real("R8 period unchanged", period, 36.0);
        @(negedge clk);
        sleep_req = 1'b1;
        #200;
        r0 = rises;
        #200;
        chk_int("R9 no edges in sleep", rises, r0);
        chk_int("R9 enable reads one in sleep", reg_rdata[0], 1);
        chk_real("R9 whole pulses", min_high, 18.0);
        @(negedge clk);
        sleep_req = 1'b0;
        #400;
        chk_int("R9 resumes after wake", (rises > r0) ? 1 : 0, 1);
        chk_real("R9 period after wake", period, 36.0);
        write_word(word(0, 0, 0, 0));
        wait_off("R6 div2");
    endtask

    // R10: enable written during sleep
    task automatic t_enable_in_sleep();
        int r0;
        clear_meas();
        @(negedge clk);
        sleep_req = 1'b1;
        write_word(word(1, 0, 3, 0));
        r0 = rises;
        #300;
        chk_int("R10 no output in sleep", rises, r0);
        chk_int("R10 readback in sleep", reg_rdata, word(1, 0, 3, 0));
        @(negedge clk);
        sleep_req = 1'b0;
        #400;
        chk_real("R10 period after wake", period, 22.0);
        chk_real("R10 high after wake", high_t, 11.0);
        write_word(word(0, 0, 0, 0));
        wait_off("R10");
    endtask

    initial begin
        #7;
        t_reset();
        #10;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_plain();
        t_div0();
        t_div2_sleep();
        t_enable_in_sleep();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule